// File: doc/BRIEF.md
# USB Full-Speed Frame Interval Timer

This block keeps the host-side frame timing of a full-speed USB controller. A bit-time enable strobe drives a down-counter that holds the bit times left in the current frame. When that count is spent, the counter reloads from a programmable interval, the frame number advances and a one-cycle start-of-frame event is raised. A second event fires whenever the top bit of the frame number flips, so software can extend the frame number beyond 16 bits.

Software programs the interval register and a periodic-start threshold, and reads the interval, the remaining time and the frame number. The remaining-time register carries a toggle bit that is copied from the interval register at each reload, so software can tell when a newly written interval has taken effect. A registered priority flag tells the scheduler when the remaining time has fallen to the threshold, which is the point where periodic traffic gets priority.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the interval register reads 11999 in bits 13:0, the reset packet size in bits 30:16 and 0 in bit 31. The threshold reads 10799. The remaining register and the frame number read 0, both events are low and the priority flag is high.
- R2: Writing the interval register stores the frame interval in bits 13:0, the maximum packet size in bits 30:16 and the toggle in bit 31. Bits 15:14 always read 0.
- R3: On a bit-time strobe with a non-zero remaining count, the count drops by one. With no strobe, every counter holds its value.
- R4: On a strobe with a zero remaining count, bits 13:0 of the remaining register load the interval field held before that edge, and bit 31 loads the interval toggle.
- R5: Writing the interval register does not change the remaining register. The new interval is first used at the next reload.
- R6: The frame number rises by one at each reload, wraps from 0xFFFF to 0, and changes at no other time.
- R7: The start-of-frame event is high for exactly the one cycle after each reload edge, and low at all other times.
- R8: The overflow event is high for the one cycle after an edge where bit 15 of the frame number changed, in either direction, and low at all other times.
- R9: The priority flag is high exactly when bits 13:0 of the remaining register are at or below the 14-bit threshold, which is written through its own port.
- R10: Bits 30:14 of the remaining register always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-time strobe, one per full-speed bit time |
| ivl_wr | input | 1 | Write strobe for the interval register |
| ivl_wdata | input | 32 | Interval register write data |
| thr_wr | input | 1 | Write strobe for the periodic-start threshold |
| thr_wdata | input | 14 | Threshold write data |
| ivl_q | output | 32 | Interval register readback |
| thr_q | output | 14 | Threshold readback |
| remain_q | output | 32 | Remaining bit times (13:0) and toggle (31) |
| frame_num | output | 16 | Frame number |
| sof_pulse | output | 1 | Start-of-frame event |
| fno_pulse | output | 1 | Frame-number top-bit change event |
| periodic_pri | output | 1 | Remaining time at or below threshold |

## Verification
The bound checker checks the per-edge rules on every cycle: the decrement, the reload source and the toggle copy, that the frame number only moves with a start-of-frame, that both events stay quiet without a strobe, that the overflow event matches a change of bit 15, the threshold comparison, and the zero reserved bits. The bench scenarios cover what needs history or chosen stimulus. These are the reset values, the readback of reserved interval bits, a write in mid-frame that leaves the count alone and shows up only after the next reload, and a full 65536-frame run at interval zero. That run must give exactly two overflow events and return to the starting frame number.

// File: rtl/ftm_pkg.sv
package ftm_pkg;
  localparam int FI_W    = 14;
  localparam int MPS_W   = 15;
  localparam int REG_W   = 32;
  localparam int RSVD_W  = 16 - FI_W;

  typedef struct packed {
    logic             tog;
    logic [MPS_W-1:0] mps;
    logic [RSVD_W-1:0] rsvd;
    logic [FI_W-1:0]  fi;
  } ivl_reg_t;
endpackage

// File: rtl/ftm_cfg_regs.sv
module ftm_cfg_regs
  import ftm_pkg::*;
#(
  parameter int FI_RST  = 11999,
  parameter int MPS_RST = 0,
  parameter int PS_RST  = 10799
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ivl_wr,
  input  logic [REG_W-1:0] ivl_wdata,
  input  logic             thr_wr,
  input  logic [FI_W-1:0]  thr_wdata,
  output ivl_reg_t         ivl_q,
  output logic [FI_W-1:0]  thr_q,
  output logic [FI_W-1:0]  thr_d
);
  ivl_reg_t wr_val;

  always_comb begin
    wr_val      = ivl_reg_t'(ivl_wdata);
    wr_val.rsvd = '0;
    thr_d       = thr_wr ? thr_wdata : thr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ivl_q.tog  <= 1'b0;
      ivl_q.mps  <= MPS_W'(MPS_RST);
      ivl_q.rsvd <= '0;
      ivl_q.fi   <= FI_W'(FI_RST);
      thr_q      <= FI_W'(PS_RST);
    end else begin
      if (ivl_wr) ivl_q <= wr_val;
      thr_q <= thr_d;
    end
  end
endmodule

// File: rtl/ftm_remain_ctr.sv
module ftm_remain_ctr
  import ftm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_en,
  input  logic [FI_W-1:0] load_val,
  input  logic            load_tog,
  output logic [FI_W-1:0] rem_q,
  output logic [FI_W-1:0] rem_d,
  output logic            tog_q,
  output logic            reload
);
  logic tog_d;

  always_comb begin
    reload = bit_en && (rem_q == '0);
    rem_d  = rem_q;
    tog_d  = tog_q;
    if (reload) begin
      rem_d = load_val;
      tog_d = load_tog;
    end else if (bit_en) begin
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      tog_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      tog_q <= tog_d;
    end
  end
endmodule

// File: rtl/ftm_frame_ctr.sv
module ftm_frame_ctr #(
  parameter int FN_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            advance,
  output logic [FN_W-1:0] fn_q,
  output logic            sof_q,
  output logic            fno_q
);
  localparam int TOP = FN_W - 1;
  logic [FN_W-1:0] fn_next;

  assign fn_next = fn_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_q  <= '0;
      sof_q <= 1'b0;
      fno_q <= 1'b0;
    end else begin
      sof_q <= advance;
      fno_q <= advance && (fn_next[TOP] != fn_q[TOP]);
      if (advance) fn_q <= fn_next;
    end
  end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import ftm_pkg::*;
#(
  parameter int FN_W    = 16,
  parameter int FI_RST  = 11999,
  parameter int MPS_RST = 0,
  parameter int PS_RST  = 10799
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             ivl_wr,
  input  logic [REG_W-1:0] ivl_wdata,
  input  logic             thr_wr,
  input  logic [FI_W-1:0]  thr_wdata,
  output logic [REG_W-1:0] ivl_q,
  output logic [FI_W-1:0]  thr_q,
  output logic [REG_W-1:0] remain_q,
  output logic [FN_W-1:0]  frame_num,
  output logic             sof_pulse,
  output logic             fno_pulse,
  output logic             periodic_pri
);
  localparam int PAD_W = REG_W - FI_W - 1;

  ivl_reg_t        ivl_s;
  logic [FI_W-1:0] thr_d;
  logic [FI_W-1:0] rem_q;
  logic [FI_W-1:0] rem_d;
  logic            tog_q;
  logic            reload;

  ftm_cfg_regs #(
    .FI_RST (FI_RST),
    .MPS_RST(MPS_RST),
    .PS_RST (PS_RST)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .ivl_wr   (ivl_wr),
    .ivl_wdata(ivl_wdata),
    .thr_wr   (thr_wr),
    .thr_wdata(thr_wdata),
    .ivl_q    (ivl_s),
    .thr_q    (thr_q),
    .thr_d    (thr_d)
  );

  ftm_remain_ctr u_rem (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .load_val(ivl_s.fi),
    .load_tog(ivl_s.tog),
    .rem_q   (rem_q),
    .rem_d   (rem_d),
    .tog_q   (tog_q),
    .reload  (reload)
  );

  ftm_frame_ctr #(.FN_W(FN_W)) u_fn (
    .clk    (clk),
    .rst    (rst),
    .advance(reload),
    .fn_q   (frame_num),
    .sof_q  (sof_pulse),
    .fno_q  (fno_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) periodic_pri <= 1'b1;
    else     periodic_pri <= (rem_d <= thr_d);
  end

  assign ivl_q    = REG_W'(ivl_s);
  assign remain_q = {tog_q, {PAD_W{1'b0}}, rem_q};
endmodule

// File: rtl/ftm_checker.sv
module ftm_checker #(
  parameter int FN_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            bit_en,
  input logic [31:0]     ivl_q,
  input logic [13:0]     thr_q,
  input logic [31:0]     remain_q,
  input logic [FN_W-1:0] frame_num,
  input logic            sof_pulse,
  input logic            fno_pulse,
  input logic            periodic_pri
);
  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && remain_q[13:0] != 14'd0) |=> remain_q[13:0] == $past(remain_q[13:0]) - 14'd1);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(remain_q) && $stable(frame_num)));

  // R4
  reload_src_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && remain_q[13:0] == 14'd0) |=>
      (remain_q[13:0] == $past(ivl_q[13:0]) && remain_q[31] == $past(ivl_q[31])));

  // R6
  fn_step_chk: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |-> (frame_num - $past(frame_num)) == FN_W'(1));

  // R6
  fn_still_chk: assert property (@(posedge clk) disable iff (rst)
    !sof_pulse |-> frame_num == $past(frame_num));

  // R7
  sof_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> !sof_pulse);

  // R8
  fno_match_chk: assert property (@(posedge clk) disable iff (rst)
    fno_pulse == (frame_num[FN_W-1] != $past(frame_num[FN_W-1])));

  // R9
  pri_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    periodic_pri == (remain_q[13:0] <= thr_q));

  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    remain_q[30:14] == 17'd0);
endmodule

bind usb_frame_timer ftm_checker #(.FN_W(FN_W)) u_ftm_chk (
  .clk         (clk),
  .rst         (rst),
  .bit_en      (bit_en),
  .ivl_q       (ivl_q),
  .thr_q       (thr_q),
  .remain_q    (remain_q),
  .frame_num   (frame_num),
  .sof_pulse   (sof_pulse),
  .fno_pulse   (fno_pulse),
  .periodic_pri(periodic_pri)
);

// File: tb/usb_frame_timer_bench.sv
`timescale 1ns/1ps
module usb_frame_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        ivl_wr = 1'b0;
  logic [31:0] ivl_wdata = '0;
  logic        thr_wr = 1'b0;
  logic [13:0] thr_wdata = '0;
  logic [31:0] ivl_q;
  logic [13:0] thr_q;
  logic [31:0] remain_q;
  logic [15:0] frame_num;
  logic        sof_pulse, fno_pulse, periodic_pri;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  usb_frame_timer u_usb_frame_timer (
    .clk(clk), .rst(rst), .bit_en(bit_en),
    .ivl_wr(ivl_wr), .ivl_wdata(ivl_wdata),
    .thr_wr(thr_wr), .thr_wdata(thr_wdata),
    .ivl_q(ivl_q), .thr_q(thr_q), .remain_q(remain_q),
    .frame_num(frame_num), .sof_pulse(sof_pulse),
    .fno_pulse(fno_pulse), .periodic_pri(periodic_pri)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_ivl, m_ps, m_rem, m_tog, m_fn, m_sof, m_fno, m_pri;

  always @(posedge clk) begin
    bit s_rst, s_be, s_iw, s_pw;
    int s_id, s_pd;
    s_rst = rst; s_be = bit_en; s_iw = ivl_wr; s_pw = thr_wr;
    s_id = int'(ivl_wdata); s_pd = int'(thr_wdata);
    #1;
    if (s_rst) begin
      m_ivl = 11999; m_ps = 10799; m_rem = 0; m_tog = 0;
      m_fn = 0; m_sof = 0; m_fno = 0;
    end else begin
      m_sof = 0; m_fno = 0;
      if (s_be && m_rem == 0) begin
        int nf;
        m_rem = m_ivl & 16'h3fff;
        m_tog = (m_ivl >>> 31) & 1;
        nf = (m_fn + 1) % 65536;
        m_fno = ((nf / 32768) != (m_fn / 32768)) ? 1 : 0;
        m_fn = nf;
        m_sof = 1;
      end else if (s_be) begin
        m_rem = m_rem - 1;
      end
      if (s_iw) m_ivl = s_id & ~32'h0000c000;
      if (s_pw) m_ps = s_pd;
    end
    m_pri = (m_rem <= m_ps) ? 1 : 0;
    check("R2 ivl", ivl_q, longint'(unsigned'(m_ivl)));
    check("R9 thr", thr_q, m_ps);
    check("R3/R4 remain", remain_q, (longint'(m_tog) << 31) | m_rem);
    check("R6 frame", frame_num, m_fn);
    check("R7 sof", sof_pulse, m_sof);
    check("R8 fno", fno_pulse, m_fno);
    check("R9 pri", periodic_pri, m_pri);
  end

  task automatic step(input bit be);
    @(negedge clk);
    bit_en = be; ivl_wr = 1'b0; thr_wr = 1'b0;
  endtask

  task automatic wr_ivl(input logic [31:0] d, input bit be);
    @(negedge clk);
    bit_en = be; ivl_wr = 1'b1; ivl_wdata = d; thr_wr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int start_fn, n_fno, n_sof;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 ivl", ivl_q, 32'd11999);
    check("R1 thr", thr_q, 10799);
    check("R1 remain", remain_q, 0);
    check("R1 frame", frame_num, 0);
    check("R1 pri", periodic_pri, 1);
    check("R1 sof", sof_pulse, 0);

    // R2 write with reserved bits set
    wr_ivl(32'hC123_C005, 1'b0);
    step(1'b0);
    check("R2 readback", ivl_q, 32'hC123_0005);
    check("R3 no strobe hold", remain_q, 0);

    // R4 first strobe reloads
    step(1'b1);
    step(1'b0);
    check("R4 reload", remain_q, 32'h8000_0005);
    check("R7 sof", sof_pulse, 1);
    check("R6 frame", frame_num, 1);
    step(1'b0);
    check("R7 one cycle", sof_pulse, 0);

    // R3 countdown with gapped strobes
    for (int i = 0; i < 3; i++) begin step(1'b1); step(1'b0); end
    check("R3 countdown", remain_q, 32'h8000_0002);

    // R5 write mid-frame, count untouched
    wr_ivl(32'h0000_0003, 1'b0);
    step(1'b0);
    check("R5 untouched", remain_q, 32'h8000_0002);
    repeat (3) step(1'b1);
    step(1'b0);
    check("R5 new interval used", remain_q, 32'h0000_0003);

    // R9 threshold
    @(negedge clk); bit_en = 1'b0; thr_wr = 1'b1; thr_wdata = 14'd2;
    step(1'b0);
    check("R9 above thr", periodic_pri, 0);
    step(1'b1);
    step(1'b0);
    check("R9 at thr", periodic_pri, 1);

    // mixed strobe pattern
    for (int i = 0; i < 40; i++) step(((i % 3) != 1) ? 1'b1 : 1'b0);

    // R8 / R6 full wrap at interval zero
    wr_ivl(32'h0000_0000, 1'b1);
    repeat (20) step(1'b1);
    start_fn = frame_num;
    n_fno = 0; n_sof = 0;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      n_fno += fno_pulse;
      n_sof += sof_pulse;
    end
    check("R8 two overflow events", n_fno, 2);
    check("R7 sof per frame", n_sof, 65536);
    check("R6 wrap returns", frame_num, start_fn);
    step(1'b0);
    step(1'b0);
    check("R7 quiet without strobe", sof_pulse, 0);
    check("R10 reserved zero", remain_q[30:14], 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule